// File: doc/BRIEF.md
# Conversion Window Comparator with Interrupt Qualifier

This block sits behind an analog-to-digital converter. It judges each finished conversion against a window that software programs, and it decides whether that conversion should raise the converter interrupt. The converter hands over the eight most significant result bits on a valid/ready stream input. `res_ready` is tied high, so the block never applies back-pressure, and every cycle with `res_valid` high counts as one completed conversion. Software programs an upper threshold, a lower threshold and a control word through a simple write port. It acknowledges the interrupt with a one-cycle clear pulse.

The match decision is the sense bit XORed with two comparisons: whether the upper threshold is less than or equal to the result, and whether the lower threshold is less than or equal to the result. When the upper threshold is above the lower one, this gives an "inside" test (sense 0) or an "outside" test (sense 1). Other threshold orderings follow the same formula with no special case. A qualify bit selects one of two rules. In the first, every completion raises the interrupt. In the second, only a completion that matches raises it. Either rule applies only while the interrupt enable is set.

Top module: `wc_qualifier`

## Requirements
- R1: After reset, `match_o` and `irq_o` are 0, both thresholds are 0, and all control bits are 0.
- R2: A write with `wr_en` high stores `wr_data` into the register at `wr_addr`. Address 0 is the upper threshold and address 1 is the lower threshold. Address 2 is the control word: bit 0 is sense, bit 1 is qualify, bit 2 is interrupt enable. A write to address 3 changes nothing.
- R3: On a cycle with `res_valid` high, the block evaluates sense ^ (upper <= msbs) ^ (lower <= msbs), with unsigned comparisons. `match_o` shows the result from the next cycle on.
- R4: With upper > lower and sense 0, a result matches exactly when lower <= msbs < upper.
- R5: With upper > lower and sense 1, a result matches exactly when msbs >= upper or msbs < lower.
- R6: When upper <= lower, the formula of R3 applies unchanged. With equal thresholds, the match equals the sense bit.
- R7: `match_o` holds its value on every cycle without `res_valid`, even when the thresholds or the control word change.
- R8: With enable 1 and qualify 0, every completion sets `irq_o` on the next cycle, whatever the match is.
- R9: With enable 1 and qualify 1, a completion sets `irq_o` only if that completion matches.
- R10: With enable 0, no completion sets `irq_o`.
- R11: Once set, `irq_o` stays high until a cycle with `irq_clr` high. It reads 0 on the cycle after that clear.
- R12: If a completion that sets `irq_o` and an `irq_clr` pulse fall in the same cycle, `irq_o` is 1 on the next cycle.
- R13: A register write in the same cycle as a completion does not affect that completion. The completion uses the values held before the write.
- R14: `res_ready` is 1 at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Completed conversion present |
| res_ready | output | 1 | Always 1; no back-pressure |
| res_msbs | input | DW (8) | Upper eight result bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DW (8) | Register write data |
| irq_clr | input | 1 | Interrupt acknowledge pulse |
| match_o | output | 1 | Window match of the last completion |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
There is one register between a completion and either result. Both `match_o` and `irq_o` are due on the clock edge that samples `res_valid`, and a clear takes effect on the edge that samples `irq_clr`. The bench drives every stimulus for exactly one cycle starting at a falling edge. It then reads the outputs at the following falling edge, which lands one edge after the stimulus. For the hold and sticky cases, the bench idles several more cycles and checks that the outputs do not move. These cases include register writes between completions.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_UPPER = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOWER = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic irq_en;
    logic qualify;
    logic sense;
  } ctrl_t;
endpackage

// File: rtl/wc_regs.sv
module wc_regs
  import wc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     upper_q,
  output logic [DW-1:0]     lower_q,
  output ctrl_t             ctrl_q
);
  localparam int NREG = 2;

  logic [DW-1:0] thr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        thr_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL)
      ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  assign upper_q = thr_q[A_UPPER];
  assign lower_q = thr_q[A_LOWER];
endmodule

// File: rtl/wc_compare.sv
module wc_compare #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] msbs,
  input  logic [DW-1:0] upper,
  input  logic [DW-1:0] lower,
  input  logic          sense,
  output logic          hit
);
  logic upper_le, lower_le;

  always_comb begin
    upper_le = (upper <= msbs);
    lower_le = (lower <= msbs);
    hit      = sense ^ upper_le ^ lower_le;
  end
endmodule

// File: rtl/wc_irq.sv
module wc_irq
  import wc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done,
  input  logic  hit,
  input  ctrl_t ctrl,
  input  logic  clr,
  output logic  match_o,
  output logic  irq_o
);
  logic set_req;

  always_comb begin
    set_req = done && ctrl.irq_en && (!ctrl.qualify || hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      match_o <= 1'b0;
    else if (done)
      match_o <= hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_o <= 1'b0;
    else if (set_req)
      irq_o <= 1'b1;
    else if (clr)
      irq_o <= 1'b0;
  end
endmodule

// File: rtl/wc_qualifier.sv
module wc_qualifier
  import wc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DW-1:0]     res_msbs,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              irq_clr,
  output logic              match_o,
  output logic              irq_o
);
  logic [DW-1:0] upper_q, lower_q;
  ctrl_t         ctrl_q;
  logic          hit;

  assign res_ready = 1'b1;

  wc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upper_q(upper_q), .lower_q(lower_q), .ctrl_q(ctrl_q)
  );

  wc_compare #(.DW(DW)) u_cmp (
    .msbs(res_msbs), .upper(upper_q), .lower(lower_q),
    .sense(ctrl_q.sense), .hit(hit)
  );

  wc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(res_valid), .hit(hit), .ctrl(ctrl_q),
    .clr(irq_clr), .match_o(match_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker
  import wc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  res_valid,
  input logic  irq_clr,
  input logic  match_o,
  input logic  irq_o,
  input ctrl_t ctrl
);
  assert_match_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(match_o));

  assert_every_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ctrl.irq_en && !ctrl.qualify |=> irq_o);

  assert_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && ctrl.irq_en && ctrl.qualify && !irq_o |=> irq_o == match_o);

  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.irq_en && !irq_o |=> !irq_o);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr |=> irq_o);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !res_valid |=> !irq_o);
endmodule

bind wc_qualifier wc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .irq_clr(irq_clr),
  .match_o(match_o), .irq_o(irq_o), .ctrl(ctrl_q)
);

// File: tb/tb_wc_qualifier.sv
`timescale 1ns/1ps
module tb_wc_qualifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [7:0] res_msbs = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_clr = 1'b0;
  logic       match_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  wc_qualifier dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_msbs(res_msbs), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .match_o(match_o), .irq_o(irq_o)
  );

  function automatic bit model(input logic [7:0] up, input logic [7:0] lo,
                               input bit s, input logic [7:0] m);
    return s ^ (up <= m) ^ (lo <= m);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] up, input logic [7:0] lo, input logic [2:0] c);
    wr(2'd0, up); wr(2'd1, lo); wr(2'd2, {5'd0, c});
  endtask

  task automatic done(input logic [7:0] m);
    res_valid = 1'b1; res_msbs = m;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 match", match_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R14 ready", res_ready, 1'b1);
    // zero thresholds, sense 0: 0^1^1 = 0; enable 0 so no interrupt
    done(8'd7);
    chk("R1 match default regs", match_o, 1'b0);
    chk("R10 irq default disabled", irq_o, 1'b0);
  endtask

  task automatic t_inside();
    cfg(8'd100, 8'd20, 3'b110);
    done(8'd20);  chk("R4 lower bound", match_o, 1'b1);
    chk("R9 match irq", irq_o, 1'b1);
    clear();      chk("R11 cleared", irq_o, 1'b0);
    done(8'd99);  chk("R4 below upper", match_o, 1'b1);
    clear();
    done(8'd100); chk("R4 at upper", match_o, 1'b0);
    chk("R9 no irq on miss", irq_o, 1'b0);
    done(8'd19);  chk("R4 below lower", match_o, 1'b0);
    chk("R9 no irq on miss2", irq_o, 1'b0);
    done(8'd57);  chk("R3 model", match_o, model(8'd100, 8'd20, 0, 8'd57));
    clear();
  endtask

  task automatic t_outside();
    cfg(8'd100, 8'd20, 3'b111);
    done(8'd100); chk("R5 at upper", match_o, 1'b1);
    done(8'd19);  chk("R5 below lower", match_o, 1'b1);
    done(8'd50);  chk("R5 inside", match_o, 1'b0);
    done(8'd255); chk("R5 top", match_o, 1'b1);
    clear();
  endtask

  task automatic t_inverted();
    cfg(8'd20, 8'd100, 3'b000);
    done(8'd50);  chk("R6 between", match_o, 1'b1);
    done(8'd10);  chk("R6 low", match_o, 1'b0);
    done(8'd150); chk("R6 high", match_o, 1'b0);
    cfg(8'd50, 8'd50, 3'b001);
    done(8'd50);  chk("R6 equal sense1 a", match_o, 1'b1);
    done(8'd0);   chk("R6 equal sense1 b", match_o, 1'b1);
    wr(2'd2, 8'd0);
    done(8'd49);  chk("R6 equal sense0", match_o, 1'b0);
  endtask

  task automatic t_hold();
    cfg(8'd100, 8'd20, 3'b000);
    done(8'd30);  chk("R7 set", match_o, 1'b1);
    cfg(8'd10, 8'd5, 3'b001);
    repeat (3) @(negedge clk);
    chk("R7 held", match_o, 1'b1);
  endtask

  task automatic t_qual0();
    cfg(8'd100, 8'd20, 3'b100);
    done(8'd5);   chk("R8 miss still raises", irq_o, 1'b1);
    chk("R8 match low", match_o, 1'b0);
    repeat (4) @(negedge clk);
    chk("R11 sticky", irq_o, 1'b1);
    clear();      chk("R11 clear", irq_o, 1'b0);
    wr(2'd2, 8'd000);
    done(8'd50);  chk("R10 disabled", irq_o, 1'b0);
    chk("R10 match still updates", match_o, 1'b1);
  endtask

  task automatic t_setclr();
    cfg(8'd100, 8'd20, 3'b110);
    res_valid = 1'b1; res_msbs = 8'd40; irq_clr = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; irq_clr = 1'b0;
    chk("R12 set wins", irq_o, 1'b1);
    clear();
  endtask

  task automatic t_same_cycle_write();
    cfg(8'd100, 8'd20, 3'b000);
    res_valid = 1'b1; res_msbs = 8'd50;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd30;
    @(negedge clk);
    res_valid = 1'b0; wr_en = 1'b0;
    chk("R13 old upper used", match_o, 1'b1);
    done(8'd50);  chk("R13 new upper after", match_o, 1'b0);
  endtask

  task automatic t_addr3();
    cfg(8'd100, 8'd20, 3'b000);
    wr(2'd3, 8'h07);
    done(8'd50);  chk("R2 addr3 ctrl unchanged", match_o, 1'b1);
    chk("R2 addr3 no enable", irq_o, 1'b0);
    wr(2'd3, 8'd10);
    done(8'd15);  chk("R2 addr3 thresholds unchanged", match_o, 1'b0);
    chk("R14 ready idle", res_ready, 1'b1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    #1;
    chk("R14 ready in reset", res_ready, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inside();
    t_outside();
    t_inverted();
    t_hold();
    t_qual0();
    t_setclr();
    t_same_cycle_write();
    t_addr3();
    report();
    $finish;
  end
endmodule